// File: doc/BRIEF.md
# Video Control Register I2C Slave

This block is a write-only I2C target that holds the control settings of a video processing path. It samples SCL and SDA with the system clock through two-flop synchronizers and detects START and STOP. It accepts only the write address built from a fixed 7-bit address, followed by a subaddress and one or more data bytes. It acknowledges each accepted byte by pulling SDA low during the ninth clock pulse.

Data bytes can land in the active registers at once, with the subaddress advancing after each byte. When the buffer-enable bit is set, the block instead keeps a single pending byte and copies it into place on the next vertical-blanking strobe. Until that copy happens it refuses further writes.

The stored bytes are decoded into level outputs for the video path: six-bit adjustment values, mode flags and a source selection. The source selection combines the stored switch bits with two external switch inputs. A supply-fail input returns every register to 0x01.

Top module: `vidctl_i2c_regs`

## Requirements
- R1: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. A START that arrives in the middle of a byte abandons that byte, and address matching begins again.
- R2: Only the address byte {SLAVE_ADDR, 0} (0x88 by default) is acknowledged. Any other address byte, including one with the read bit set, gets no acknowledge, and the rest of the transfer is ignored.
- R3: Subaddresses 0x00 to 0x0F are acknowledged. A subaddress of 0x10 or above is not acknowledged, and nothing is written.
- R4: With buffer-enable clear, an acknowledged data byte reaches the outputs before its acknowledge pulse ends.
- R5: Each further data byte in a transfer goes to the next subaddress. The counter wraps from 0x0F to 0x00.
- R6: Subaddresses 0x07, 0x08, 0x09, 0x0B and 0x0F are acknowledged. Writing them changes no output, but the counter still steps past them.
- R7: With buffer-enable set, an accepted data byte is held back. It reaches its register only on the first clock with vblank_i high.
- R8: With buffer-enable set, only the first data byte of a transfer is acknowledged. While a byte is pending, the address byte of every new transfer is not acknowledged.
- R9: Registers 0x00 to 0x06 and 0x0A drive the six-bit outputs from bits 5:0. Register 0x0C bit 7 drives sc_two_level_o, bit 5 is buffer-enable and bit 3 drives ntsc_o. Register 0x0D bit 4 drives cutoff_off_o, and register 0x0E bit 5 drives clamp_mode_o.
- R10: Register 0x0D bits 3:0 are {dis2, on2, dis1, on1}. src_sel_o is 2 (second RGB input) when on2=1 or (fsw2_i=1 and dis2=0). Otherwise it is 1 (first RGB input) when on1=1 or (fsw1_i=1 and dis1=0). Otherwise it is 0 (luminance/colour-difference). The value 3 never occurs.
- R11: Reset, or pfail_i high at a clock edge, sets every register to 0x01 and drops any pending byte.
- R12: sda_oe_o is high only from the falling SCL edge after the eighth bit of an acknowledged byte to the following falling SCL edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, well above the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| pfail_i | input | 1 | Supply-fail indication, synchronous |
| vblank_i | input | 1 | Vertical-blanking strobe that commits a pending byte |
| scl_i | input | 1 | I2C clock line |
| sda_i | input | 1 | I2C data line as seen on the bus |
| sda_oe_o | output | 1 | Pull SDA low (acknowledge) when high |
| fsw1_i | input | 1 | External switch for the first RGB input |
| fsw2_i | input | 1 | External switch for the second RGB input |
| bright_o | output | 6 | Brightness, register 0x00 |
| sat_o | output | 6 | Saturation, register 0x01 |
| contrast_o | output | 6 | Contrast, register 0x02 |
| hue_o | output | 6 | Hue voltage code, register 0x03 |
| gain_r_o | output | 6 | Red gain, register 0x04 |
| gain_g_o | output | 6 | Green gain, register 0x05 |
| gain_b_o | output | 6 | Blue gain, register 0x06 |
| peak_o | output | 6 | Peak drive limit, register 0x0A |
| sc_two_level_o | output | 1 | Two-level sandcastle selected |
| buf_en_o | output | 1 | Buffered (vertical-blank) update mode |
| ntsc_o | output | 1 | NTSC matrix selected |
| cutoff_off_o | output | 1 | Automatic cut-off loop disabled |
| clamp_mode_o | output | 1 | Output clamp mode with brightness off |
| src_sel_o | output | 2 | Selected source: 0 Y/CD, 1 RGB1, 2 RGB2 |

## Verification
The bench builds the block with its default address parameter, 0x44, so the accepted byte is 0x88. It uses a bus phase of five system clocks. This gives the synchronizers and edge detectors real latency to cross, and it puts every acknowledge and release check a few cycles after the internal edge detection. Directed transfers reach the subaddress wrap, the reserved slots, the refused subaddresses, a START cut into an address byte and the whole buffered-commit cycle. Random transfers then mix immediate and buffered mode, refused addresses and supply-fail pulses, with a bench register model keeping track.

// File: rtl/vidctl_i2c_regs.sv
module vidctl_i2c_regs #(
  parameter logic [6:0] SLAVE_ADDR = 7'h44,
  parameter logic [7:0] FAIL_VALUE = 8'h01
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pfail_i,
  input  logic       vblank_i,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o,
  input  logic       fsw1_i,
  input  logic       fsw2_i,
  output logic [5:0] bright_o,
  output logic [5:0] sat_o,
  output logic [5:0] contrast_o,
  output logic [5:0] hue_o,
  output logic [5:0] gain_r_o,
  output logic [5:0] gain_g_o,
  output logic [5:0] gain_b_o,
  output logic [5:0] peak_o,
  output logic       sc_two_level_o,
  output logic       buf_en_o,
  output logic       ntsc_o,
  output logic       cutoff_off_o,
  output logic       clamp_mode_o,
  output logic [1:0] src_sel_o
);
  localparam int NREG = 16;
  localparam logic [7:0] WR_ADDR = {SLAVE_ADDR, 1'b0};

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_SUB, S_DATA, S_SKIP} phase_t;

  logic [1:0] scl_sy, sda_sy;
  logic       scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sy <= 2'b11;
      sda_sy <= 2'b11;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_i};
      sda_sy <= {sda_sy[0], sda_i};
      scl_q  <= scl_sy[1];
      sda_q  <= sda_sy[1];
    end

  wire scl_s    = scl_sy[1];
  wire sda_s    = sda_sy[1];
  wire start_c  = scl_s & scl_q & sda_q & ~sda_s;
  wire stop_c   = scl_s & scl_q & ~sda_q & sda_s;
  wire scl_rise = scl_s & ~scl_q;
  wire scl_fall = ~scl_s & scl_q;

  phase_t     ph;
  logic [3:0] bit_cnt;
  logic [7:0] shreg;
  logic       ack_ph;
  logic       got_one;
  logic [3:0] ptr;
  logic [7:0] rf [NREG];
  logic       pend;
  logic [3:0] pidx;
  logic [7:0] pdat;

  function automatic logic rsv(input logic [3:0] a);
    return (a == 4'h7) || (a == 4'h8) || (a == 4'h9) || (a == 4'hB) || (a == 4'hF);
  endfunction

  wire receiving = (ph == S_ADDR) || (ph == S_SUB) || (ph == S_DATA);
  wire buf_on    = rf[12][5];
  wire byte_done = scl_fall & ~ack_ph & (bit_cnt == 4'd8) & receiving;

  logic ack_ok;
  always_comb
    case (ph)
      S_ADDR:  ack_ok = (shreg == WR_ADDR) & ~pend;
      S_SUB:   ack_ok = (shreg[7:4] == 4'h0);
      S_DATA:  ack_ok = ~(buf_on & got_one);
      default: ack_ok = 1'b0;
    endcase

  wire data_ok = byte_done & (ph == S_DATA) & ack_ok & ~rsv(ptr);
  wire wr_now  = data_ok & ~buf_on;
  wire wr_buf  = data_ok & buf_on;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ph       <= S_IDLE;
      bit_cnt  <= 4'd0;
      shreg    <= 8'h00;
      ack_ph   <= 1'b0;
      got_one  <= 1'b0;
      ptr      <= 4'h0;
      sda_oe_o <= 1'b0;
    end else if (start_c) begin
      ph       <= S_ADDR;
      bit_cnt  <= 4'd0;
      ack_ph   <= 1'b0;
      sda_oe_o <= 1'b0;
    end else if (stop_c) begin
      ph       <= S_IDLE;
      bit_cnt  <= 4'd0;
      ack_ph   <= 1'b0;
      sda_oe_o <= 1'b0;
    end else if (scl_rise && !ack_ph && bit_cnt < 4'd8 && receiving) begin
      shreg   <= {shreg[6:0], sda_s};
      bit_cnt <= bit_cnt + 4'd1;
    end else if (byte_done) begin
      sda_oe_o <= ack_ok;
      ack_ph   <= ack_ok;
      if (!ack_ok) ph <= S_SKIP;
      else
        case (ph)
          S_ADDR: ph <= S_SUB;
          S_SUB: begin
            ph      <= S_DATA;
            ptr     <= shreg[3:0];
            got_one <= 1'b0;
          end
          default: begin
            ptr     <= ptr + 4'h1;
            got_one <= 1'b1;
          end
        endcase
    end else if (scl_fall && ack_ph) begin
      sda_oe_o <= 1'b0;
      ack_ph   <= 1'b0;
      bit_cnt  <= 4'd0;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) rf[i] <= FAIL_VALUE;
      pend <= 1'b0;
      pidx <= 4'h0;
      pdat <= 8'h00;
    end else if (pfail_i) begin
      for (int i = 0; i < NREG; i++) rf[i] <= FAIL_VALUE;
      pend <= 1'b0;
    end else begin
      if (vblank_i && pend) begin
        rf[pidx] <= pdat;
        pend     <= 1'b0;
      end
      if (wr_now) rf[ptr] <= shreg;
      if (wr_buf) begin
        pend <= 1'b1;
        pidx <= ptr;
        pdat <= shreg;
      end
    end

  assign bright_o       = rf[0][5:0];
  assign sat_o          = rf[1][5:0];
  assign contrast_o     = rf[2][5:0];
  assign hue_o          = rf[3][5:0];
  assign gain_r_o       = rf[4][5:0];
  assign gain_g_o       = rf[5][5:0];
  assign gain_b_o       = rf[6][5:0];
  assign peak_o         = rf[10][5:0];
  assign sc_two_level_o = rf[12][7];
  assign buf_en_o       = buf_on;
  assign ntsc_o         = rf[12][3];
  assign cutoff_off_o   = rf[13][4];
  assign clamp_mode_o   = rf[14][5];

  wire [3:0] fs = rf[13][3:0];
  assign src_sel_o = (fs[2] | (fsw2_i & ~fs[3])) ? 2'd2 :
                     (fs[0] | (fsw1_i & ~fs[1])) ? 2'd1 : 2'd0;

  logic rf_unused;
  always_comb begin
    rf_unused = 1'b0;
    for (int i = 0; i < NREG; i++) rf_unused = rf_unused ^ (^rf[i]);
  end

  a_r12_ack_window: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe_o |-> ack_ph);
  a_r2_read_nack: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && ph == S_ADDR && shreg[0]) |=> !sda_oe_o);
  a_r3_bad_sub_nack: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && ph == S_SUB && shreg[7:4] != 4'h0) |=> !sda_oe_o);
  a_r7_commit: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && vblank_i && !pfail_i) |=> !pend);
  a_r8_no_direct_write: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> !wr_now);
  a_r11_supply_fail: assert property (@(posedge clk) disable iff (!rst_n)
    pfail_i |=> (bright_o == FAIL_VALUE[5:0] && peak_o == FAIL_VALUE[5:0] && !pend));
  a_r10_sel_legal: assert property (@(posedge clk) disable iff (!rst_n)
    src_sel_o != 2'd3);
endmodule

// File: tb/tb_vidctl_i2c_regs.sv
module tb_vidctl_i2c_regs;
  localparam int Q = 5;

  logic clk = 1'b0, rst_n = 1'b0, pfail = 1'b0, vbl = 1'b0;
  logic scl = 1'b1, sda_d = 1'b1, fsw1 = 1'b0, fsw2 = 1'b0;
  wire  sda_oe;
  wire  sda_line = sda_d & ~sda_oe;
  wire [5:0] bright, sat, contrast, hue, gr, gg, gb, peak;
  wire sc2, bufen, ntsc, cutoff, clampm;
  wire [1:0] src;

  vidctl_i2c_regs dut (
    .clk(clk), .rst_n(rst_n), .pfail_i(pfail), .vblank_i(vbl),
    .scl_i(scl), .sda_i(sda_line), .sda_oe_o(sda_oe),
    .fsw1_i(fsw1), .fsw2_i(fsw2),
    .bright_o(bright), .sat_o(sat), .contrast_o(contrast), .hue_o(hue),
    .gain_r_o(gr), .gain_g_o(gg), .gain_b_o(gb), .peak_o(peak),
    .sc_two_level_o(sc2), .buf_en_o(bufen), .ntsc_o(ntsc),
    .cutoff_off_o(cutoff), .clamp_mode_o(clampm), .src_sel_o(src));

  always #5 clk = ~clk;

  int checks = 0, fails = 0;
  logic [7:0] e [16];
  logic       pend_m = 1'b0;
  logic [3:0] pidx_m = 4'h0;
  logic [7:0] pdat_m = 8'h00;
  logic [7:0] dbuf [20];

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic rsv_m(input logic [3:0] a);
    return a == 4'h7 || a == 4'h8 || a == 4'h9 || a == 4'hB || a == 4'hF;
  endfunction

  function automatic logic [52:0] exp_vec();
    return {e[0][5:0], e[1][5:0], e[2][5:0], e[3][5:0], e[4][5:0], e[5][5:0],
            e[6][5:0], e[10][5:0], e[12][7], e[12][5], e[12][3], e[13][4], e[14][5]};
  endfunction

  function automatic logic [1:0] exp_src(input logic [7:0] d, input logic f1, input logic f2);
    if (d[2] || (f2 && !d[3])) return 2'd2;
    if (d[0] || (f1 && !d[1])) return 2'd1;
    return 2'd0;
  endfunction

  wire [52:0] dut_vec = {bright, sat, contrast, hue, gr, gg, gb, peak, sc2, bufen, ntsc, cutoff, clampm};

  task automatic verify(input string tag);
    chk(tag, 64'(dut_vec), 64'(exp_vec()));
    chk({tag, " src"}, 64'(src), 64'(exp_src(e[13], fsw1, fsw2)));
  endtask

  task automatic i2c_start;
    sda_d = 1'b1; tick(Q); scl = 1'b1; tick(Q); sda_d = 1'b0; tick(Q); scl = 1'b0; tick(Q);
  endtask

  task automatic i2c_stop;
    sda_d = 1'b0; tick(Q); scl = 1'b1; tick(Q); sda_d = 1'b1; tick(Q);
  endtask

  task automatic put_bit(input logic b);
    sda_d = b; tick(Q); scl = 1'b1; tick(Q); scl = 1'b0; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, input logic exp_ack, input string tag, output logic got);
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    sda_d = 1'b1; tick(Q); scl = 1'b1; tick(Q);
    got = ~sda_line;
    chk(tag, 64'(got), 64'(exp_ack));
    scl = 1'b0; tick(Q);
    if (got) chk("R12 release after ninth pulse", 64'(sda_oe), 64'd0);
  endtask

  task automatic xfer(input logic [7:0] ab, input logic [7:0] sub, input int n, input string tag);
    logic a, ea;
    logic [3:0] p;
    i2c_start;
    ea = (ab == 8'h88) && !pend_m;
    send_byte(ab, ea, {tag, " R2/R8 address ack"}, a);
    if (a) begin
      send_byte(sub, sub < 8'h10, {tag, " R3 subaddress ack"}, a);
      if (a) begin
        p = sub[3:0];
        for (int k = 0; k < n; k++) begin
          ea = !(e[12][5] && k > 0);
          send_byte(dbuf[k], ea, {tag, " R8 data ack"}, a);
          if (!a) break;
          if (!rsv_m(p)) begin
            if (!e[12][5]) e[p] = dbuf[k];
            else begin pend_m = 1'b1; pidx_m = p; pdat_m = dbuf[k]; end
          end
          p = p + 4'h1;
        end
      end
    end
    i2c_stop;
    tick(2);
  endtask

  task automatic blank_pulse;
    vbl = 1'b1; tick(1); vbl = 1'b0; tick(2);
    if (pend_m) begin e[pidx_m] = pdat_m; pend_m = 1'b0; end
  endtask

  task automatic fail_pulse;
    pfail = 1'b1; tick(1); pfail = 1'b0; tick(1);
    for (int i = 0; i < 16; i++) e[i] = 8'h01;
    pend_m = 1'b0;
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 16; i++) e[i] = 8'h01;
    tick(3); rst_n = 1'b1; tick(3);
    verify("R11 reset state");

    for (int i = 0; i < 16; i++) dbuf[i] = 8'h30 + 8'(i);
    dbuf[12] = 8'h88; dbuf[13] = 8'h10; dbuf[14] = 8'h20;
    xfer(8'h88, 8'h00, 16, "R4/R5");
    verify("R9 field map after full write R4 R5");

    dbuf[0] = 8'h00; dbuf[1] = 8'h55; dbuf[2] = 8'h2A;
    xfer(8'h88, 8'h0E, 3, "R5 wrap");
    verify("R5 wrap 0x0F to 0x00");

    dbuf[0] = 8'hFF; dbuf[1] = 8'hFF; dbuf[2] = 8'hFF;
    xfer(8'h88, 8'h07, 4, "R6");
    xfer(8'h88, 8'h0B, 1, "R6");
    xfer(8'h88, 8'h0F, 1, "R6");
    verify("R6 reserved slots no effect");

    dbuf[0] = 8'h3F;
    xfer(8'h8A, 8'h00, 1, "R2 wrong address");
    xfer(8'h89, 8'h00, 1, "R2 read bit");
    verify("R2 refused address no effect");
    xfer(8'h88, 8'h10, 1, "R3 bad subaddress");
    xfer(8'h88, 8'hF2, 1, "R3 bad subaddress");
    verify("R3 refused subaddress no effect");

    i2c_start;
    put_bit(1'b1); put_bit(1'b0); put_bit(1'b0); put_bit(1'b0);
    dbuf[0] = 8'h15;
    xfer(8'h88, 8'h02, 1, "R1 restart");
    verify("R1 START mid-byte then clean transfer");

    dbuf[0] = 8'h20;
    xfer(8'h88, 8'h0C, 1, "R7 enable buffer");
    verify("R7 buffer mode on");
    dbuf[0] = 8'h11; dbuf[1] = 8'h22;
    xfer(8'h88, 8'h01, 2, "R8 second byte");
    verify("R7 data held before blanking");
    dbuf[0] = 8'h33;
    xfer(8'h88, 8'h00, 1, "R8 blocked transfer");
    verify("R8 blocked write no effect");
    blank_pulse;
    verify("R7 committed at blanking");
    dbuf[0] = 8'h00;
    xfer(8'h88, 8'h0C, 1, "R7 disable buffer");
    blank_pulse;
    verify("R7 buffer mode off");

    for (int v = 0; v < 16; v++) begin
      dbuf[0] = 8'(v);
      xfer(8'h88, 8'h0D, 1, "R10 switch bits");
      for (int f = 0; f < 4; f++) begin
        fsw1 = f[0]; fsw2 = f[1]; tick(1);
        chk("R10 source priority", 64'(src), 64'(exp_src(8'(v), f[0], f[1])));
      end
    end

    fail_pulse;
    verify("R11 supply fail");

    for (int it = 0; it < 90; it++) begin
      logic [7:0] ab, sb;
      int n;
      ab = ($urandom % 10 == 0) ? 8'($urandom) : 8'h88;
      sb = 8'($urandom % 20);
      n  = 1 + int'($urandom % 4);
      for (int k = 0; k < n; k++) dbuf[k] = 8'($urandom);
      fsw1 = 1'($urandom); fsw2 = 1'($urandom);
      xfer(ab, sb, n, "random");
      if ($urandom % 4 == 0) blank_pulse;
      if ($urandom % 25 == 0) fail_pulse;
      verify("R4 R7 random transfer");
    end

    finish_run;
  end
endmodule